// File: doc/BRIEF.md
# B-Channel HDLC Receive Block Buffer

This block sits between the deframing logic of one B-channel HDLC receiver and a microprocessor. The receiver hands it payload bytes, one per strobe, plus a strobe that marks the end of each frame. Bytes are stored in a 64-entry first-in first-out store. Software drains them one byte per read strobe from a single read port, oldest byte first.

Software does not poll byte by byte. The block divides the incoming stream into blocks and announces each one with an interrupt. A threshold of 32 or 48 bytes sets the block size. A full-size block is announced once the unannounced bytes outnumber the threshold. A frame's tail is announced as a short block, never longer than the threshold, with its exact length shown on the block length output. Each announcement holds until software acknowledges it, and only then can the next one be raised.

A command write carries three bits. The first acknowledges the current block. The second flushes the receive side. The third arms or disarms the receiver.

Top module: `bchan_rx_buffer`

## Requirements
- R1: After reset the level, block length, both interrupts and the overflow flag read 0, and the receiver is disarmed.
- R2: While the receiver is disarmed (after reset, or after a command write with `cmd_rx_enable` = 0), byte strobes and end-of-frame strobes change neither the level nor any interrupt.
- R3: Bytes are read out in the order they were accepted. `rd_data` shows the oldest byte, each `rd_en` cycle removes one, and `fifo_level` counts the stored bytes. A read of an empty store has no effect.
- R4: `cfg_thr48` = 0 selects a threshold of 32 and 1 selects 48. When the count of unannounced bytes exceeds the threshold and no interrupt is pending, `irq_blk_ready` rises with `blk_len` equal to the threshold.
- R5: After an end-of-frame strobe, once the frame's unannounced bytes number at most the threshold and no interrupt is pending, `irq_frame_end` rises with `blk_len` equal to that count. The count includes a byte that arrives in the same cycle as the strobe.
- R6: A frame longer than the threshold is announced as full blocks first. Its remainder is then announced with `irq_frame_end` after the acknowledge of the last full block.
- R7: A raised interrupt stays high until an acknowledge or a receive flush. At most one of the two interrupts is high at a time, and bytes that arrive meanwhile raise nothing new.
- R8: A command write with `cmd_ack` = 1 clears a pending interrupt at the next edge. Any next block is raised one cycle later. An acknowledge with nothing pending has no effect.
- R9: A byte that arrives while the store holds 64 bytes is dropped, and `overflow` is set. It stays set until a receive flush.
- R10: A command write with `cmd_rx_reset` = 1 empties the store, clears both interrupts, the pending frame end and `overflow`, and discards any byte that arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_thr48 | input | 1 | Threshold select: 0 gives 32 bytes, 1 gives 48 bytes |
| cmd_valid | input | 1 | Command write strobe |
| cmd_ack | input | 1 | Command bit: acknowledge the announced block |
| cmd_rx_reset | input | 1 | Command bit: flush the receive side |
| cmd_rx_enable | input | 1 | Command bit: new value of the receiver-armed state |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| in_frame_end | input | 1 | End-of-frame strobe from the deframer |
| rd_en | input | 1 | Software read strobe; removes the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| fifo_level | output | 7 | Number of stored bytes |
| blk_len | output | 7 | Length of the block most recently announced |
| irq_blk_ready | output | 1 | Full block ready interrupt |
| irq_frame_end | output | 1 | Frame tail ready interrupt |
| overflow | output | 1 | Sticky dropped-byte flag |

## Verification
The length properties assume that `cfg_thr48` changes only while no interrupt is pending and no unannounced bytes are waiting. The stimulus switches it only after the store has drained and the last block has been acknowledged. The properties also assume that software reads no further than the blocks announced so far, except in the overflow scenario. There the bench deliberately empties all 64 bytes and then flushes the receive side before it counts blocks again. End-of-frame strobes are spaced so that a new frame never ends while an earlier end is still waiting for its announcement.

// File: rtl/bchan_rx_pkg.sv
package bchan_rx_pkg;

    typedef enum logic [1:0] {
        BLK_NONE  = 2'd0,
        BLK_READY = 2'd1,
        BLK_END   = 2'd2
    } blk_kind_e;

    typedef struct packed {
        logic active;
        logic flush;
        logic ack;
    } rx_ctl_t;

    // Threshold in bytes: half the depth or three quarters of it.
    function automatic int thr_bytes(input logic sel_hi, input int depth);
        return sel_hi ? (depth * 3) / 4 : depth / 2;
    endfunction

endpackage

// File: rtl/bchan_rx_cmd.sv
module bchan_rx_cmd
    import bchan_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_valid,
    input  logic    cmd_ack,
    input  logic    cmd_rx_reset,
    input  logic    cmd_rx_enable,
    output rx_ctl_t ctl
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (cmd_valid) begin
            armed_q <= cmd_rx_enable;
        end
    end

    always_comb begin
        ctl.active = armed_q;
        ctl.flush  = cmd_valid && cmd_rx_reset;
        ctl.ack    = cmd_valid && cmd_ack;
    end

endmodule

// File: rtl/bchan_rx_store.sv
module bchan_rx_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ok,
    output logic [CNT_W-1:0]  level,
    output logic              overflow
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp_q, rp_q;
    logic [AW-1:0]     wp_nx, rp_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovf_q;
    logic              do_rd, do_wr;

    assign do_rd = rd_req && (cnt_q != '0);
    assign do_wr = wr_req && ((cnt_q != CNT_W'(DEPTH)) || do_rd);

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wp_nx = wp_q + AW'(1);
            assign rp_nx = rp_q + AW'(1);
        end else begin : g_wrap
            assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (do_wr) wp_q <= wp_nx;
            if (do_rd) rp_q <= rp_nx;
            cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
            if (wr_req && !do_wr) ovf_q <= 1'b1;
        end
    end

    assign rd_data  = mem[rp_q];
    assign wr_ok    = do_wr;
    assign level    = cnt_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/bchan_rx_blocks.sv
module bchan_rx_blocks
    import bchan_rx_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             thr_sel,
    input  logic             byte_in,
    input  logic             frame_end,
    input  logic             ack,
    output logic             irq_ready,
    output logic             irq_end,
    output logic [CNT_W-1:0] blk_len
);

    blk_kind_e        cur_q, cur_d;
    logic [CNT_W-1:0] unrel_q, unrel_d;
    logic             eof_pend_q, eof_pend_d;
    logic [CNT_W-1:0] eof_left_q, eof_left_d;
    logic [CNT_W-1:0] len_q, len_d;
    logic [CNT_W-1:0] thr;
    logic             idle, sel_end, sel_rdy;
    logic [CNT_W-1:0] rel_amt;

    assign thr     = CNT_W'(thr_bytes(thr_sel, DEPTH));
    assign idle    = (cur_q == BLK_NONE);
    assign sel_end = idle && eof_pend_q && (eof_left_q <= thr);
    assign sel_rdy = idle && !sel_end && (unrel_q > thr);

    always_comb begin
        rel_amt = '0;
        if (sel_end)      rel_amt = eof_left_q;
        else if (sel_rdy) rel_amt = thr;

        unrel_d = unrel_q - rel_amt + CNT_W'(byte_in);

        eof_pend_d = eof_pend_q;
        eof_left_d = eof_left_q;
        if (sel_end) begin
            eof_pend_d = 1'b0;
            eof_left_d = '0;
        end else if (sel_rdy && eof_pend_q) begin
            eof_left_d = eof_left_q - thr;
        end
        if (frame_end) begin
            eof_pend_d = 1'b1;
            eof_left_d = unrel_d;
        end

        cur_d = cur_q;
        len_d = len_q;
        if (ack && !idle) begin
            cur_d = BLK_NONE;
        end else if (sel_end) begin
            cur_d = BLK_END;
            len_d = eof_left_q;
        end else if (sel_rdy) begin
            cur_d = BLK_READY;
            len_d = thr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cur_q      <= BLK_NONE;
            unrel_q    <= '0;
            eof_pend_q <= 1'b0;
            eof_left_q <= '0;
            len_q      <= '0;
        end else begin
            cur_q      <= cur_d;
            unrel_q    <= unrel_d;
            eof_pend_q <= eof_pend_d;
            eof_left_q <= eof_left_d;
            len_q      <= len_d;
        end
    end

    assign irq_ready = (cur_q == BLK_READY);
    assign irq_end   = (cur_q == BLK_END);
    assign blk_len   = len_q;

endmodule

// File: rtl/bchan_rx_buffer.sv
module bchan_rx_buffer
    import bchan_rx_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_thr48,
    input  logic              cmd_valid,
    input  logic              cmd_ack,
    input  logic              cmd_rx_reset,
    input  logic              cmd_rx_enable,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_frame_end,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fifo_level,
    output logic [CNT_W-1:0]  blk_len,
    output logic              irq_blk_ready,
    output logic              irq_frame_end,
    output logic              overflow
);

    rx_ctl_t ctl;
    logic    push_req, push_ok, end_ok;

    bchan_rx_cmd u_cmd (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_ack       (cmd_ack),
        .cmd_rx_reset  (cmd_rx_reset),
        .cmd_rx_enable (cmd_rx_enable),
        .ctl           (ctl)
    );

    assign push_req = in_valid && ctl.active && !ctl.flush;
    assign end_ok   = in_frame_end && ctl.active && !ctl.flush;

    bchan_rx_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (ctl.flush),
        .wr_req   (push_req),
        .wr_data  (in_data),
        .rd_req   (rd_en),
        .rd_data  (rd_data),
        .wr_ok    (push_ok),
        .level    (fifo_level),
        .overflow (overflow)
    );

    bchan_rx_blocks #(
        .DEPTH (DEPTH)
    ) u_blocks (
        .clk       (clk),
        .rst       (rst),
        .flush     (ctl.flush),
        .thr_sel   (cfg_thr48),
        .byte_in   (push_ok),
        .frame_end (end_ok),
        .ack       (ctl.ack),
        .irq_ready (irq_blk_ready),
        .irq_end   (irq_frame_end),
        .blk_len   (blk_len)
    );

endmodule

// File: rtl/bchan_rx_buffer_chk.sv
module bchan_rx_buffer_chk
    import bchan_rx_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_thr48,
    input logic             cmd_valid,
    input logic             cmd_ack,
    input logic             cmd_rx_reset,
    input logic             in_valid,
    input logic             rd_en,
    input logic [CNT_W-1:0] fifo_level,
    input logic [CNT_W-1:0] blk_len,
    input logic             irq_blk_ready,
    input logic             irq_frame_end,
    input logic             overflow
);

    logic [CNT_W-1:0] thr;
    logic             release_cmd;

    assign thr         = CNT_W'(thr_bytes(cfg_thr48, DEPTH));
    assign release_cmd = cmd_valid && (cmd_ack || cmd_rx_reset);

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= CNT_W'(DEPTH));

    // R4
    ready_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_blk_ready) |-> blk_len == thr);

    // R5
    end_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_frame_end) |-> blk_len <= thr);

    // R7
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_blk_ready && irq_frame_end));

    // R7
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq_blk_ready && !release_cmd |=> irq_blk_ready);

    // R7
    end_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq_frame_end && !release_cmd |=> irq_frame_end);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ack && (irq_blk_ready || irq_frame_end)
        |=> !irq_blk_ready && !irq_frame_end);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow && !(cmd_valid && cmd_rx_reset) |=> overflow);

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_level == CNT_W'(DEPTH) && in_valid && !rd_en && !cmd_valid
        |=> fifo_level == CNT_W'(DEPTH));

    // R10
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_rx_reset
        |=> fifo_level == '0 && !overflow && !irq_blk_ready && !irq_frame_end);

endmodule

bind bchan_rx_buffer bchan_rx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_thr48     (cfg_thr48),
    .cmd_valid     (cmd_valid),
    .cmd_ack       (cmd_ack),
    .cmd_rx_reset  (cmd_rx_reset),
    .in_valid      (in_valid),
    .rd_en         (rd_en),
    .fifo_level    (fifo_level),
    .blk_len       (blk_len),
    .irq_blk_ready (irq_blk_ready),
    .irq_frame_end (irq_frame_end),
    .overflow      (overflow)
);

// File: tb/bchan_rx_buffer_tb.sv
module bchan_rx_buffer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_thr48 = 1'b0;
    logic       cmd_valid = 1'b0, cmd_ack = 1'b0, cmd_rx_reset = 1'b0, cmd_rx_enable = 1'b0;
    logic       in_valid = 1'b0, in_frame_end = 1'b0, rd_en = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [7:0] rd_data;
    logic [6:0] fifo_level, blk_len;
    logic       irq_blk_ready, irq_frame_end, overflow;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q [$];
    byte unsigned seed = 8'h11;

    always #5 clk = ~clk;

    bchan_rx_buffer u_dut (
        .clk (clk), .rst (rst), .cfg_thr48 (cfg_thr48),
        .cmd_valid (cmd_valid), .cmd_ack (cmd_ack),
        .cmd_rx_reset (cmd_rx_reset), .cmd_rx_enable (cmd_rx_enable),
        .in_valid (in_valid), .in_data (in_data), .in_frame_end (in_frame_end),
        .rd_en (rd_en), .rd_data (rd_data), .fifo_level (fifo_level),
        .blk_len (blk_len), .irq_blk_ready (irq_blk_ready),
        .irq_frame_end (irq_frame_end), .overflow (overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: pushes the byte to the scoreboard when it should be kept.
    task automatic send_byte(input logic keep);
        seed = seed * 8'd13 + 8'd7;
        in_valid = 1'b1;
        in_data  = seed;
        if (keep) exp_q.push_back(seed);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_many(input int n, input logic keep);
        for (int i = 0; i < n; i++) send_byte(keep);
    endtask

    task automatic send_end();
        in_frame_end = 1'b1;
        @(negedge clk);
        in_frame_end = 1'b0;
    endtask

    task automatic command(input logic a, input logic r, input logic e);
        cmd_valid = 1'b1; cmd_ack = a; cmd_rx_reset = r; cmd_rx_enable = e;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_ack = 1'b0; cmd_rx_reset = 1'b0;
    endtask

    task automatic read_n(input int n);
        if (n > 0) begin
            rd_en = 1'b1;
            repeat (n) @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    // Monitor: compares each byte removed against the scoreboard (R3).
    always @(negedge clk) begin
        #1;
        if (!rst && rd_en && fifo_level != 0) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3: read %0d with empty scoreboard, expected none", rd_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL R3: read data actual %0d expected %0d", rd_data, e);
                end
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 level", fifo_level, 0);
        chk("R1 irq", {irq_blk_ready, irq_frame_end}, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 blk_len", blk_len, 0);

        // R2 disarmed receiver ignores bytes and frame end
        send_many(5, 1'b0);
        send_end();
        tick(3);
        chk("R2 level disarmed", fifo_level, 0);
        chk("R2 irq disarmed", irq_frame_end, 0);

        // Arm, short frame: R5
        command(1'b0, 1'b0, 1'b1);
        send_many(10, 1'b1);
        send_end();
        tick(3);
        chk("R5 end irq", irq_frame_end, 1);
        chk("R5 end len", blk_len, 10);
        chk("R3 level", fifo_level, 10);

        // R7 pending interrupt blocks new announcements
        send_many(40, 1'b1);
        tick(3);
        chk("R7 ready held off", irq_blk_ready, 0);
        chk("R7 end still high", irq_frame_end, 1);
        read_n(10);
        chk("R3 level after read", fifo_level, 40);

        // R8 ack clears; next block one cycle later (R4)
        command(1'b1, 1'b0, 1'b1);
        chk("R8 cleared", {irq_blk_ready, irq_frame_end}, 0);
        tick(1);
        chk("R4 ready irq", irq_blk_ready, 1);
        chk("R4 ready len 32", blk_len, 32);
        read_n(32);
        command(1'b1, 1'b0, 1'b1);
        tick(3);
        chk("R4 below threshold", {irq_blk_ready, irq_frame_end}, 0);
        send_end();
        tick(3);
        chk("R5 tail irq", irq_frame_end, 1);
        chk("R5 tail len", blk_len, 8);
        read_n(8);
        command(1'b1, 1'b0, 1'b1);
        tick(2);

        // R6 long frame split
        send_many(40, 1'b1);
        send_end();
        tick(3);
        chk("R6 full block first", irq_blk_ready, 1);
        chk("R6 full len", blk_len, 32);
        chk("R6 no end yet", irq_frame_end, 0);
        read_n(32);
        command(1'b1, 1'b0, 1'b1);
        tick(3);
        chk("R6 remainder irq", irq_frame_end, 1);
        chk("R6 remainder len", blk_len, 8);
        read_n(8);
        command(1'b1, 1'b0, 1'b1);
        tick(2);

        // R4 threshold 48
        cfg_thr48 = 1'b1;
        send_many(48, 1'b1);
        tick(3);
        chk("R4 48 not exceeded", irq_blk_ready, 0);
        send_byte(1'b1);
        tick(2);
        chk("R4 48 exceeded", irq_blk_ready, 1);
        chk("R4 len 48", blk_len, 48);
        read_n(48);
        command(1'b1, 1'b0, 1'b1);
        tick(2);
        send_end();
        tick(3);
        chk("R5 one byte tail", blk_len, 1);
        chk("R5 one byte irq", irq_frame_end, 1);
        read_n(1);
        command(1'b1, 1'b0, 1'b1);
        tick(2);
        cfg_thr48 = 1'b0;
        chk("R3 drained", fifo_level, 0);

        // R9 overflow
        send_many(64, 1'b1);
        send_many(2, 1'b0);
        tick(1);
        chk("R9 level full", fifo_level, 64);
        chk("R9 overflow set", overflow, 1);
        read_n(64);
        chk("R9 overflow sticky", overflow, 1);
        chk("R3 empty", fifo_level, 0);
        read_n(2);
        chk("R3 empty read ignored", fifo_level, 0);

        // R10 receive flush
        send_many(5, 1'b1);
        command(1'b0, 1'b1, 1'b1);
        exp_q.delete();
        chk("R10 level", fifo_level, 0);
        chk("R10 overflow", overflow, 0);
        chk("R10 irq", {irq_blk_ready, irq_frame_end}, 0);
        send_many(3, 1'b1);
        send_end();
        tick(3);
        chk("R10 still armed", irq_frame_end, 1);
        chk("R5 len after flush", blk_len, 3);
        read_n(3);
        command(1'b1, 1'b0, 1'b1);
        tick(2);

        // R8 ack with nothing pending
        command(1'b1, 1'b0, 1'b1);
        tick(2);
        chk("R8 idle ack", {irq_blk_ready, irq_frame_end}, 0);
        chk("R8 idle ack level", fifo_level, 0);

        // R2 disarm by command
        command(1'b0, 1'b0, 1'b0);
        send_many(4, 1'b0);
        send_end();
        tick(3);
        chk("R2 level after disarm", fifo_level, 0);
        chk("R2 irq after disarm", irq_frame_end, 0);
        chk("R3 scoreboard empty", exp_q.size(), 0);

        report();
    end

endmodule